// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits on the host write path of an 8-input programmable interrupt controller. It takes byte writes qualified by one address-select line and walks the start-up command-word sequence. That sequence has a variable length. The first word, written with the select line low and a marker bit set, always starts a new sequence and says what follows. The second word always comes next. A third word is taken only when the controller is cascaded, and a fourth word is taken only when the first word asked for it. Every word after the first is written with the select line high.

The captured fields leave the block as stable configuration outputs:
- call-address interval
- single or cascaded operation
- edge or level triggering
- vector address bits
- the cascade byte
- the fourth-word options

A ready flag says when the sequence is complete. Once the block is ready, select-high writes load the interrupt mask. Other operational commands pass by untouched, because priority logic downstream handles them.

Top module: `intc_init_seq`

## Requirements
- R1: In reset and just after it, cfgReady is low and every configuration output and maskBits are zero.
- R2: A write with addrSel=0 and wrData[4]=1 is a first word, accepted in any state. It captures wrData[0] (fourth word follows), wrData[1] (singleMode), wrData[2] (intervalFour, 1 = interval 4) and wrData[3] (levelTrig). It clears cascadeWord and the fourth-word options. After that clock edge cfgReady is low and the sequence restarts.
- R3: For interval 4 (wrData[2]=1), the first word's bits 7..5 go to vecLow[2:0]. For interval 8, bits 7..6 go to vecLow[2:1] and vecLow[0] is 0.
- R4: The next addrSel=1 write after a first word is the second word, and its whole byte goes to vecHigh.
- R5: When singleMode=0, the addrSel=1 write after the second word is the third word, and its whole byte goes to cascadeWord (a slave identity sits in bits 2..0). When singleMode=1, the third word is skipped.
- R6: The fourth word is taken only when the first word's bit 0 was 1. It sets cpu16=bit0, autoEoi=bit1, bufMaster=bit2, buffered=bit3 and nestedSpecial=bit4. When it is skipped, these outputs stay 0.
- R7: cfgReady rises at the clock edge that takes the last expected word, and at that same edge maskBits becomes 0.
- R8: While cfgReady is low, addrSel=1 writes with no sequence pending are ignored, as are addrSel=0 writes with wrData[4]=0. maskBits never changes.
- R9: While cfgReady is high, an addrSel=1 write loads maskBits, and an addrSel=0 write with wrData[4]=0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per byte |
| addrSel | input | 1 | Address select line |
| wrData | input | 8 | Write data byte |
| cfgReady | output | 1 | Initialization complete |
| intervalFour | output | 1 | 1 = call-address interval 4, 0 = interval 8 |
| singleMode | output | 1 | 1 = single controller, 0 = cascaded |
| levelTrig | output | 1 | 1 = level triggered inputs |
| vecLow | output | 3 | Vector address bits 7..5 |
| vecHigh | output | 8 | Vector address bits 15..8 |
| cascadeWord | output | 8 | Cascade map or slave identity |
| cpu16 | output | 1 | 16-bit processor mode |
| autoEoi | output | 1 | Automatic end-of-interrupt |
| bufMaster | output | 1 | Master select in buffered mode |
| buffered | output | 1 | Buffered mode |
| nestedSpecial | output | 1 | Special fully nested mode |
| maskBits | output | 8 | Interrupt mask register |

## Verification
The sequence is driven in all four lengths: two words, three words with a cascade byte, three words with a fourth word, and the full four. Separate cases catch a sequencer that expects a word it should skip, and one that skips a word it should expect. Interval 4 and interval 8 first words carry a set bit 5, which shows whether vecLow[0] is forced to zero. A first word written partway through a longer sequence, followed by a short one, shows that the restart clears the old cascade and option fields. Stray select-high writes before any first word, and command writes while idle or busy, show that nothing leaks into the mask or shifts the sequence.

// File: rtl/intc_init_pkg.sv
package intc_init_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_WANT2,
    ST_WANT3,
    ST_WANT4,
    ST_READY
  } seq_state_t;

  typedef struct packed {
    logic ldFirst;
    logic ldSecond;
    logic ldThird;
    logic ldFourth;
    logic ldMask;
    logic finish;
  } strobe_t;

  localparam int MARK_BIT  = 4;
  localparam int F_IC4     = 0;
  localparam int F_SINGLE  = 1;
  localparam int F_INTV4   = 2;
  localparam int F_LEVEL   = 3;
  localparam int O_CPU16   = 0;
  localparam int O_AEOI    = 1;
  localparam int O_BUFMST  = 2;
  localparam int O_BUF     = 3;
  localparam int O_NESTED  = 4;
  localparam int VEC_LO_W  = 3;
endpackage

// File: rtl/intc_init_ctrl.sv
module intc_init_ctrl
  import intc_init_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cascaded,
  input  logic              wantFourth,
  output strobe_t           strobes,
  output logic              ready
);
  seq_state_t state, nextState;
  logic isFirst, isData;

  assign isFirst = wrEn && !addrSel && wrData[MARK_BIT];
  assign isData  = wrEn && addrSel;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (isFirst) begin
      strobes.ldFirst = 1'b1;
      nextState       = ST_WANT2;
    end else if (isData) begin
      case (state)
        ST_WANT2: begin
          strobes.ldSecond = 1'b1;
          if (cascaded) begin
            nextState = ST_WANT3;
          end else if (wantFourth) begin
            nextState = ST_WANT4;
          end else begin
            strobes.finish = 1'b1;
            nextState      = ST_READY;
          end
        end
        ST_WANT3: begin
          strobes.ldThird = 1'b1;
          if (wantFourth) begin
            nextState = ST_WANT4;
          end else begin
            strobes.finish = 1'b1;
            nextState      = ST_READY;
          end
        end
        ST_WANT4: begin
          strobes.ldFourth = 1'b1;
          strobes.finish   = 1'b1;
          nextState        = ST_READY;
        end
        ST_READY: strobes.ldMask = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_UNINIT;
    else       state <= nextState;
  end

  assign ready = (state == ST_READY);

  // R2: a first word always drops ready after its edge
  p_first_drops_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[MARK_BIT]) |=> !ready);

  // R7: ready can only rise because of a select-high write
  p_ready_from_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(wrEn && addrSel));

  // R8: no sequence pending means a select-high write cannot start one
  p_uninit_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNINIT && !(wrEn && !addrSel && wrData[MARK_BIT])) |=> state == ST_UNINIT);
endmodule

// File: rtl/intc_init_dpath.sv
module intc_init_dpath
  import intc_init_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wantFourth,
  output logic                intervalFour,
  output logic                singleMode,
  output logic                levelTrig,
  output logic [VEC_LO_W-1:0] vecLow,
  output logic [DATA_W-1:0]   vecHigh,
  output logic [DATA_W-1:0]   cascadeWord,
  output logic                cpu16,
  output logic                autoEoi,
  output logic                bufMaster,
  output logic                buffered,
  output logic                nestedSpecial,
  output logic [DATA_W-1:0]   maskBits
);
  localparam int TOP = DATA_W - 1;

  logic [VEC_LO_W-1:0] lowPick;
  assign lowPick = wrData[F_INTV4] ? wrData[TOP -: VEC_LO_W]
                                   : {wrData[TOP -: VEC_LO_W-1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wantFourth    <= 1'b0;
      intervalFour  <= 1'b0;
      singleMode    <= 1'b0;
      levelTrig     <= 1'b0;
      vecLow        <= '0;
      vecHigh       <= '0;
      cascadeWord   <= '0;
      cpu16         <= 1'b0;
      autoEoi       <= 1'b0;
      bufMaster     <= 1'b0;
      buffered      <= 1'b0;
      nestedSpecial <= 1'b0;
      maskBits      <= '0;
    end else begin
      if (strobes.ldFirst) begin
        wantFourth    <= wrData[F_IC4];
        singleMode    <= wrData[F_SINGLE];
        intervalFour  <= wrData[F_INTV4];
        levelTrig     <= wrData[F_LEVEL];
        vecLow        <= lowPick;
        cascadeWord   <= '0;
        cpu16         <= 1'b0;
        autoEoi       <= 1'b0;
        bufMaster     <= 1'b0;
        buffered      <= 1'b0;
        nestedSpecial <= 1'b0;
      end
      if (strobes.ldSecond) vecHigh     <= wrData;
      if (strobes.ldThird)  cascadeWord <= wrData;
      if (strobes.ldFourth) begin
        cpu16         <= wrData[O_CPU16];
        autoEoi       <= wrData[O_AEOI];
        bufMaster     <= wrData[O_BUFMST];
        buffered      <= wrData[O_BUF];
        nestedSpecial <= wrData[O_NESTED];
      end
      if (strobes.finish)      maskBits <= '0;
      else if (strobes.ldMask) maskBits <= wrData;
    end
  end

  // R3: interval 8 leaves vector bit 5 at zero
  p_a5_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !intervalFour |-> !vecLow[0]);

  // R5: a single controller never captures a cascade byte
  p_no_cascade_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (singleMode && $stable(singleMode)) |-> cascadeWord == '0);
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_init_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              cfgReady,
  output logic              intervalFour,
  output logic              singleMode,
  output logic              levelTrig,
  output logic [2:0]        vecLow,
  output logic [DATA_W-1:0] vecHigh,
  output logic [DATA_W-1:0] cascadeWord,
  output logic              cpu16,
  output logic              autoEoi,
  output logic              bufMaster,
  output logic              buffered,
  output logic              nestedSpecial,
  output logic [DATA_W-1:0] maskBits
);
  strobe_t strobes;
  logic    wantFourth;

  intc_init_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addrSel    (addrSel),
    .wrData     (wrData),
    .cascaded   (!singleMode),
    .wantFourth (wantFourth),
    .strobes    (strobes),
    .ready      (cfgReady)
  );

  intc_init_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (wrData),
    .wantFourth    (wantFourth),
    .intervalFour  (intervalFour),
    .singleMode    (singleMode),
    .levelTrig     (levelTrig),
    .vecLow        (vecLow),
    .vecHigh       (vecHigh),
    .cascadeWord   (cascadeWord),
    .cpu16         (cpu16),
    .autoEoi       (autoEoi),
    .bufMaster     (bufMaster),
    .buffered      (buffered),
    .nestedSpecial (nestedSpecial),
    .maskBits      (maskBits)
  );

  // R7: completion leaves the mask empty
  p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgReady) |-> maskBits == '0);

  // R8: the mask holds while not ready
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!cfgReady) && !cfgReady) |-> $stable(maskBits));

  // R6: a first word leaves the fourth-word options at zero
  p_opts_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && !addrSel && wrData[MARK_BIT]) |->
      {cpu16, autoEoi, bufMaster, buffered, nestedSpecial} == '0);
endmodule

// File: tb/sim_intc_init_seq.sv
module sim_intc_init_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic addrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic cfgReady, intervalFour, singleMode, levelTrig;
  logic [2:0] vecLow;
  logic [7:0] vecHigh, cascadeWord, maskBits;
  logic cpu16, autoEoi, bufMaster, buffered, nestedSpecial;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  intc_init_seq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrSel(addrSel), .wrData(wrData),
    .cfgReady(cfgReady), .intervalFour(intervalFour), .singleMode(singleMode),
    .levelTrig(levelTrig), .vecLow(vecLow), .vecHigh(vecHigh),
    .cascadeWord(cascadeWord), .cpu16(cpu16), .autoEoi(autoEoi),
    .bufMaster(bufMaster), .buffered(buffered), .nestedSpecial(nestedSpecial),
    .maskBits(maskBits)
  );

  // behavioural reference: pending lists the words still expected
  string pending[$];
  bit mIc4, mSingle, mIntv4, mLevel, mReady;
  bit [2:0] mVecLo;
  bit [7:0] mVecHi, mCasc, mMask;
  bit [4:0] mOpts;

  always @(posedge clk) begin
    if (!rstN) begin
      pending.delete();
      {mIc4, mSingle, mIntv4, mLevel, mReady} = '0;
      mVecLo = 0; mVecHi = 0; mCasc = 0; mMask = 0; mOpts = 0;
    end else if (wrEn && !addrSel && wrData[4]) begin
      mIc4 = wrData[0]; mSingle = wrData[1]; mIntv4 = wrData[2]; mLevel = wrData[3];
      mVecLo = mIntv4 ? wrData[7:5] : {wrData[7:6], 1'b0};
      mCasc = 0; mOpts = 0; mReady = 0;
      pending.delete();
      pending.push_back("second");
      if (!mSingle) pending.push_back("third");
      if (mIc4) pending.push_back("fourth");
    end else if (wrEn && addrSel) begin
      if (pending.size() > 0) begin
        string w;
        w = pending.pop_front();
        if (w == "second") mVecHi = wrData;
        else if (w == "third") mCasc = wrData;
        else mOpts = wrData[4:0];
        if (pending.size() == 0) begin
          mReady = 1; mMask = 0;
        end
      end else if (mReady) begin
        mMask = wrData;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [43:0] act, exp;
      act = {cfgReady, intervalFour, singleMode, levelTrig, vecLow, vecHigh, cascadeWord,
             nestedSpecial, buffered, bufMaster, autoEoi, cpu16, maskBits};
      exp = {mReady, mIntv4, mSingle, mLevel, mVecLo, mVecHi, mCasc, mOpts, mMask};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle compare actual=%h expected=%h", curTag, act, exp);
      end
    end
  end

  task automatic wr(bit a, bit [7:0] d);
    wrEn = 1'b1; addrSel = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addrSel = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", cfgReady, 0);
    chk("R1 mask", maskBits, 0);
    rstN = 1'b1;
    idle(1);
    chk("R1 vecHigh", vecHigh, 0);

    // R8: stray writes with no sequence pending
    curTag = "R8";
    wr(1, 8'h5A);
    wr(0, 8'h2F);
    chk("R8 mask unchanged", maskBits, 0);
    chk("R8 not ready", cfgReady, 0);

    // R2 R3 R4: single, interval 4, two-word sequence
    curTag = "R4";
    wr(0, 8'hB6);
    chk("R3 vecLow interval4", vecLow, 3'b101);
    chk("R2 intervalFour", intervalFour, 1);
    chk("R7 not ready mid", cfgReady, 0);
    wr(1, 8'h3C);
    chk("R4 vecHigh", vecHigh, 8'h3C);
    chk("R7 ready after two", cfgReady, 1);

    // R9: mask load and ignored command
    curTag = "R9";
    wr(1, 8'hA5);
    chk("R9 mask load", maskBits, 8'hA5);
    wr(0, 8'h20);
    chk("R9 command ignored", maskBits, 8'hA5);
    chk("R9 still ready", cfgReady, 1);

    // R5 R6 R3: cascaded, interval 8, level, full four words
    curTag = "R6";
    wr(0, 8'h79);
    chk("R2 ready drops", cfgReady, 0);
    chk("R3 vecLow interval8", vecLow, 3'b010);
    chk("R2 levelTrig", levelTrig, 1);
    chk("R7 mask kept while busy", maskBits, 8'hA5);
    wr(1, 8'h81);
    wr(0, 8'h0B);
    chk("R8 command ignored while busy", cfgReady, 0);
    wr(1, 8'h0C);
    chk("R5 cascade byte", cascadeWord, 8'h0C);
    chk("R6 not ready before fourth", cfgReady, 0);
    wr(1, 8'h1F);
    chk("R6 options", {nestedSpecial, buffered, bufMaster, autoEoi, cpu16}, 5'h1F);
    chk("R7 ready after four", cfgReady, 1);
    chk("R7 mask cleared", maskBits, 0);

    // R2: restart in the middle of a cascaded sequence
    curTag = "R2";
    wr(0, 8'h11);
    wr(1, 8'h40);
    wr(0, 8'h16);
    chk("R2 restart not ready", cfgReady, 0);
    wr(1, 8'h77);
    chk("R2 short after restart ready", cfgReady, 1);
    chk("R2 cascade cleared", cascadeWord, 0);
    chk("R6 options zero when skipped", {nestedSpecial, buffered, bufMaster, autoEoi, cpu16}, 0);

    // R5: cascaded without fourth word
    curTag = "R5";
    wr(0, 8'h10);
    wr(1, 8'h22);
    chk("R5 waiting for third", cfgReady, 0);
    wr(1, 8'h03);
    chk("R5 slave id", cascadeWord[2:0], 3'd3);
    chk("R5 ready after three", cfgReady, 1);

    // R6: single with fourth word
    curTag = "R6";
    wr(0, 8'h13);
    wr(1, 8'h99);
    chk("R6 waiting for fourth", cfgReady, 0);
    wr(1, 8'h0A);
    chk("R6 buffered", buffered, 1);
    chk("R6 autoEoi", autoEoi, 1);
    chk("R6 cpu16", cpu16, 0);
    chk("R5 no cascade in single", cascadeWord, 0);
    chk("R7 ready", cfgReady, 1);

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule